// File: doc/BRIEF.md
# E1 Transmit Channel Timing Generator

This block produces the per-timeslot timing strobes for the transmit half of a 2.048 Mbit/s E1 framer. It runs on the transmit bit clock, so one clock cycle is one bit time. It keeps its own position inside the 256-bit frame: 32 timeslots of 8 bits each, sent MSB first. It also keeps a frame parity that tells alignment frames (even) from non-alignment frames (odd). A frame-sync pulse can realign it at any time. Without that pulse it wraps freely at the end of every frame.

From this position it drives three outputs:
- a channel clock that is high during the last bit of every timeslot;
- a per-timeslot block output, set from a 32-bit channel mask;
- a demand strobe that asks an upstream source for each enabled national (Sa) bit, one bit time ahead of that bit.

It also captures the NRZ transmit data input on the falling clock edge.

The channel mask and the five-bit Sa-enable setting each have a plain synchronous write port. A written value is held as pending and only becomes active at the next frame start. A frame therefore never mixes old and new settings.

The serial data path has a fixed rate. One bit arrives and leaves per clock, so it has no valid/ready pair and no back-pressure: the upstream must present a bit on every cycle. All control pins are plain levels or single-cycle pulses.

Top module: `e1tx_chan_timer`

## Requirements
- R1: While reset is low, chclk_o, chblk_o, sa_dmd_o and ser_o are all low, and both setting registers clear to zero. The first rising edge after reset is released starts bit 0 of timeslot 0 of an even (alignment) frame.
- R2: chclk_o is high during exactly one bit time per timeslot: bit index 7 (0-based, MSB sent first at index 0), the timeslot's least significant bit.
- R3: During every bit of timeslot n, chblk_o equals bit n of the active channel mask (bit 0 ↔ timeslot 0, bit 31 ↔ timeslot 31).
- R4: A rising edge with mask_we_i high stores mask_wdata_i as pending. The pending value becomes active at the first edge that starts a frame after the write. A write on an edge that itself starts a frame takes effect only at the following frame start.
- R5: With fsync_i low, the position advances by one bit per clock, wraps from timeslot 31 bit 7 to timeslot 0 bit 0, and the frame parity toggles at each wrap.
- R6: When fsync_i is high at a rising edge (after the first edge out of reset), the bit time starting at that edge is timeslot 0, bit 0, and the frame parity toggles. This holds wherever the counters were.
- R7: In odd frames only, in timeslot 0, sa_dmd_o is high for the bit time at index k−2 when Sa bit k (k = 4..8, carried at bit index k−1) is enabled by Sa-enable bit k−4. It is low at all other times and throughout even frames.
- R8: The Sa-enable setting follows the same pending/active rule at frame starts as the channel mask (R4).
- R9: ser_o holds the value of ser_i captured at the most recent falling clock edge, and is low while reset is low.
- R10: Over any 1024 consecutive bit times without fsync_i and with a constant active Sa-enable, sa_dmd_o is high exactly twice the number of enabled Sa bits. Each enabled bit therefore adds 4 kHz to the strobe rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame-sync pulse; next bit time becomes timeslot 0 bit 0 |
| ser_i | input | 1 | NRZ transmit serial data |
| mask_we_i | input | 1 | Channel mask write strobe |
| mask_wdata_i | input | 32 | Channel mask write value, bit n for timeslot n |
| saen_we_i | input | 1 | Sa-enable write strobe |
| saen_wdata_i | input | 5 | Sa-enable write value, bit j enables Sa bit j+4 |
| chclk_o | output | 1 | Channel clock, high on each timeslot LSB |
| chblk_o | output | 1 | Per-timeslot block output |
| sa_dmd_o | output | 1 | Sa-bit demand strobe |
| ser_o | output | 1 | Falling-edge sample of ser_i |

## Verification
The main function is exercised with three channel masks:
- sparse ends (timeslots 0 and 31 plus a low nibble), which shows whether the block output maps bit n to timeslot n;
- an alternating pattern, which exposes off-by-one timeslot indexing;
- all ones, written on the very edge that starts a frame, which separates correct frame-boundary hand-over from an immediate update.

The Sa-enable setting is tried with all five bits, one bit and a two-bit mixture. These show the per-bit demand positions, the odd-frame-only rule and the pulse-rate count.

A mid-frame frame-sync pulse distinguishes realignment from free wrapping. Random serial data checks the falling-edge capture every cycle.

// File: rtl/e1tx_pkg.sv
package e1tx_pkg;
  localparam int E1_SLOTS     = 32;
  localparam int E1_SLOT_BITS = 8;
  localparam int E1_SA_FIRST  = 4;
  localparam int E1_SA_NUM    = 5;

  typedef struct packed {
    logic chclk;
    logic chblk;
    logic dmd;
  } e1tx_strobe_t;
endpackage

// File: rtl/e1tx_pos_ctr.sv
module e1tx_pos_ctr #(
  parameter int SLOTS     = e1tx_pkg::E1_SLOTS,
  parameter int SLOT_BITS = e1tx_pkg::E1_SLOT_BITS,
  localparam int POS_W    = $clog2(SLOTS * SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync_i,
  output logic [POS_W-1:0] nxt_pos_o,
  output logic             nxt_odd_o,
  output logic             frame_start_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOTS * SLOT_BITS - 1);

  logic [POS_W-1:0] pos_q;
  logic             odd_q;
  logic             run_q;

  // Look-ahead: which bit time the next edge enters.
  always_comb begin
    if (!run_q) begin
      nxt_pos_o     = '0;
      nxt_odd_o     = 1'b0;
      frame_start_o = 1'b1;
    end else if (fsync_i || pos_q == LAST_POS) begin
      nxt_pos_o     = '0;
      nxt_odd_o     = ~odd_q;
      frame_start_o = 1'b1;
    end else begin
      nxt_pos_o     = pos_q + POS_W'(1);
      nxt_odd_o     = odd_q;
      frame_start_o = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      odd_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      pos_q <= nxt_pos_o;
      odd_q <= nxt_odd_o;
      run_q <= 1'b1;
    end
  end
endmodule

// File: rtl/e1tx_frame_reg.sv
module e1tx_frame_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         frame_start_i,
  output logic [W-1:0] act_nxt_o
);
  logic [W-1:0] pend_q;
  logic [W-1:0] act_q;

  // Value in force for the bit time the next edge enters.
  always_comb act_nxt_o = frame_start_i ? pend_q : act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      act_q <= act_nxt_o;
      if (we_i) pend_q <= wdata_i;
    end
  end
endmodule

// File: rtl/e1tx_strobe_gen.sv
module e1tx_strobe_gen #(
  parameter int SLOTS     = e1tx_pkg::E1_SLOTS,
  parameter int SLOT_BITS = e1tx_pkg::E1_SLOT_BITS,
  parameter int SA_FIRST  = e1tx_pkg::E1_SA_FIRST,
  parameter int SA_NUM    = e1tx_pkg::E1_SA_NUM,
  localparam int BIT_W    = $clog2(SLOT_BITS),
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int POS_W    = BIT_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [POS_W-1:0]  nxt_pos_i,
  input  logic              nxt_odd_i,
  input  logic [SLOTS-1:0]  mask_nxt_i,
  input  logic [SA_NUM-1:0] saen_nxt_i,
  output e1tx_pkg::e1tx_strobe_t strobe_o
);
  localparam logic [BIT_W-1:0] LSB_IDX = BIT_W'(SLOT_BITS - 1);

  logic [SLOT_W-1:0] slot;
  logic [BIT_W-1:0]  bitx;
  logic [SA_NUM-1:0] sa_hit;
  e1tx_pkg::e1tx_strobe_t strobe_d;

  assign slot = nxt_pos_i[POS_W-1:BIT_W];
  assign bitx = nxt_pos_i[BIT_W-1:0];

  // One demand slot per Sa bit, one bit time ahead of it.
  for (genvar i = 0; i < SA_NUM; i++) begin : g_sa
    localparam logic [BIT_W-1:0] DMD_IDX = BIT_W'(SA_FIRST - 2 + i);
    assign sa_hit[i] = saen_nxt_i[i] && nxt_odd_i &&
                       (slot == '0) && (bitx == DMD_IDX);
  end

  always_comb begin
    strobe_d.chclk = (bitx == LSB_IDX);
    strobe_d.chblk = mask_nxt_i[slot];
    strobe_d.dmd   = |sa_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_o <= '0;
    else        strobe_o <= strobe_d;
  end
endmodule

// File: rtl/e1tx_chan_timer.sv
module e1tx_chan_timer #(
  parameter int SLOTS     = e1tx_pkg::E1_SLOTS,
  parameter int SLOT_BITS = e1tx_pkg::E1_SLOT_BITS,
  parameter int SA_FIRST  = e1tx_pkg::E1_SA_FIRST,
  parameter int SA_NUM    = e1tx_pkg::E1_SA_NUM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync_i,
  input  logic              ser_i,
  input  logic              mask_we_i,
  input  logic [SLOTS-1:0]  mask_wdata_i,
  input  logic              saen_we_i,
  input  logic [SA_NUM-1:0] saen_wdata_i,
  output logic              chclk_o,
  output logic              chblk_o,
  output logic              sa_dmd_o,
  output logic              ser_o
);
  localparam int POS_W = $clog2(SLOTS * SLOT_BITS);

  logic [POS_W-1:0]  nxt_pos;
  logic              nxt_odd;
  logic              frame_start;
  logic [SLOTS-1:0]  mask_nxt;
  logic [SA_NUM-1:0] saen_nxt;
  logic              ser_q;
  e1tx_pkg::e1tx_strobe_t strobe;

  e1tx_pos_ctr #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_pos (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i),
    .nxt_pos_o(nxt_pos), .nxt_odd_o(nxt_odd), .frame_start_o(frame_start)
  );

  e1tx_frame_reg #(.W(SLOTS)) u_mask (
    .clk(clk), .rst_n(rst_n), .we_i(mask_we_i), .wdata_i(mask_wdata_i),
    .frame_start_i(frame_start), .act_nxt_o(mask_nxt)
  );

  e1tx_frame_reg #(.W(SA_NUM)) u_saen (
    .clk(clk), .rst_n(rst_n), .we_i(saen_we_i), .wdata_i(saen_wdata_i),
    .frame_start_i(frame_start), .act_nxt_o(saen_nxt)
  );

  e1tx_strobe_gen #(
    .SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .SA_FIRST(SA_FIRST), .SA_NUM(SA_NUM)
  ) u_strb (
    .clk(clk), .rst_n(rst_n), .nxt_pos_i(nxt_pos), .nxt_odd_i(nxt_odd),
    .mask_nxt_i(mask_nxt), .saen_nxt_i(saen_nxt), .strobe_o(strobe)
  );

  // Serial data is taken on the falling edge, mid bit.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ser_q <= 1'b0;
    else        ser_q <= ser_i;
  end

  assign chclk_o  = strobe.chclk;
  assign chblk_o  = strobe.chblk;
  assign sa_dmd_o = strobe.dmd;
  assign ser_o    = ser_q;
endmodule

// File: rtl/e1tx_chan_timer_chk.sv
module e1tx_chan_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic fsync_i,
  input logic chclk_o,
  input logic chblk_o,
  input logic sa_dmd_o,
  input logic ser_o
);
  // R1: quiet outputs while held in reset
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!chclk_o && !chblk_o && !sa_dmd_o && !ser_o)
        else $error("R1 outputs active in reset");
    end
  end

  // R2: the LSB strobe lasts one bit time
  a_r2_chclk_single: assert property (@(posedge clk) disable iff (!rst_n)
    chclk_o |=> !chclk_o);

  // R6: frame sync lands on bit 0 of timeslot 0
  a_r6_fsync_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_i |=> (!chclk_o && !sa_dmd_o));

  // R3: block output changes only across a timeslot boundary
  a_r3_blk_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(chclk_o) && !$past(fsync_i)) |-> $stable(chblk_o));

  // R7: demand never falls on a timeslot LSB
  a_r7_dmd_not_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    sa_dmd_o |-> !chclk_o);
endmodule

bind e1tx_chan_timer e1tx_chan_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .chclk_o(chclk_o),
  .chblk_o(chblk_o), .sa_dmd_o(sa_dmd_o), .ser_o(ser_o)
);

// File: tb/e1tx_chan_timer_test.sv
module e1tx_chan_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync_i = 1'b0;
  logic        ser_i = 1'b0;
  logic        mask_we_i = 1'b0;
  logic [31:0] mask_wdata_i = '0;
  logic        saen_we_i = 1'b0;
  logic [4:0]  saen_wdata_i = '0;
  logic        chclk_o, chblk_o, sa_dmd_o, ser_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference state
  bit          m_run;
  int          m_pos;
  bit          m_odd;
  logic [31:0] m_mpend, m_mact;
  logic [4:0]  m_spend, m_sact;
  bit e_chclk, e_chblk, e_dmd, e_ser;
  int dmd_count;

  always #10 clk = ~clk;

  e1tx_chan_timer uut (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .ser_i(ser_i),
    .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
    .saen_we_i(saen_we_i), .saen_wdata_i(saen_wdata_i),
    .chclk_o(chclk_o), .chblk_o(chblk_o), .sa_dmd_o(sa_dmd_o), .ser_o(ser_o)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s pos=%0d odd=%0d actual=%0b expected=%0b", tag, m_pos, m_odd, act, exp);
    end
  endtask

  function automatic void model_edge();
    bit start;
    int b;
    if (!rst_n) begin
      m_run = 0; m_pos = 0; m_odd = 0;
      m_mpend = '0; m_mact = '0; m_spend = '0; m_sact = '0;
      e_chclk = 0; e_chblk = 0; e_dmd = 0; e_ser = 0;
      return;
    end
    start = !m_run || fsync_i || m_pos == 255;
    if (!m_run) begin m_pos = 0; m_odd = 0; end
    else if (start) begin m_pos = 0; m_odd = !m_odd; end
    else m_pos++;
    m_run = 1;
    if (start) begin m_mact = m_mpend; m_sact = m_spend; end
    if (mask_we_i) m_mpend = mask_wdata_i;
    if (saen_we_i) m_spend = saen_wdata_i;
    b = m_pos % 8;
    e_chclk = (b == 7);
    e_chblk = m_mact[m_pos / 8];
    e_dmd = m_odd && (m_pos / 8 == 0) && b >= 2 && b <= 6 && m_sact[b - 2];
    e_ser = ser_i;
  endfunction

  // One bit time: inputs set now (edge+13), edge, model, compare at edge+13.
  task automatic tick(input bit fs = 0, input bit mwe = 0, input logic [31:0] mwd = '0,
                      input bit swe = 0, input logic [4:0] swd = '0);
    fsync_i = fs; mask_we_i = mwe; mask_wdata_i = mwd;
    saen_we_i = swe; saen_wdata_i = swd; ser_i = 1'($urandom);
    @(posedge clk);
    model_edge();
    #13;
    check(chclk_o, e_chclk, "R2 R5 R6");
    check(chblk_o, e_chblk, "R3 R4");
    check(sa_dmd_o, e_dmd, "R7 R8");
    check(ser_o, e_ser, "R9");
    if (sa_dmd_o) dmd_count++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic rate_check(input int exp);
    dmd_count = 0;
    run(1024);
    checks++;
    if (dmd_count != exp) begin
      failures++;
      $display("FAIL R10 demand pulses actual=%0d expected=%0d", dmd_count, exp);
    end
  endtask

  initial begin
    #13;
    // R1: reset state
    for (int i = 0; i < 3; i++) tick(0, 1, 32'hFFFF_FFFF, 1, 5'h1F);
    checks++;
    if ({chclk_o, chblk_o, sa_dmd_o, ser_o} !== 4'b0) begin
      failures++;
      $display("FAIL R1 outputs in reset actual=%b expected=0000",
               {chclk_o, chblk_o, sa_dmd_o, ser_o});
    end
    rst_n = 1'b1;
    // R4 R8: writes pend until the next frame start; frame 0 uses zeros
    tick(0, 1, 32'h8000_00F1, 1, 5'b11111);
    checks++;
    if (m_pos != 0 || m_odd != 0 || chblk_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 first bit time actual=%0d/%0b expected=0/0", m_pos, chblk_o);
    end
    run(600);
    rate_check(10);                       // R10 with all five Sa bits
    tick(0, 1, 32'h5A5A_3C3C, 1, 5'b00101);
    run(300);
    while (m_pos != 255) tick();
    tick(0, 1, 32'hFFFF_FFFF);            // R4: write on a frame-start edge
    run(300);
    while (m_pos != 100) tick();
    tick(1);                              // R6: mid-frame realignment
    run(600);
    tick(0, 0, '0, 1, 5'b00001);
    run(520);
    rate_check(2);                        // R10 with one Sa bit
    tick(0, 0, '0, 1, 5'b10100);
    run(520);
    rate_check(4);                        // R10 with two Sa bits
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule